// File: doc/BRIEF.md
# Satellite-Time Oscillator Steering Controller

This block keeps a sample clock aligned to satellite time by retuning the synthesizer that produces its reference. A navigation solver delivers a time-offset estimate about every 20 ms. Each estimate is a signed nanosecond count, local time minus satellite time, with a valid strobe and a tracking-status flag. The block drives a 32-bit frequency tuning word to a direct digital synthesizer. With the synthesizer clocked at 80 MHz, one step of the word is about 18.6 mHz.

While the solver is not tracking, the word stays at its nominal value and the oscillator runs free. When tracking starts, the block watches the offset drift over a window of estimates and turns the slope into a one-shot coarse frequency correction. It then takes the next estimate as the time setpoint. From there a proportional-integral law holds the offset near that setpoint. The law updates once per control tick, which is a fixed number of estimates (500 ms of them by default), and always uses the latest estimate. Losing the tracking flag at any point drops the block back to free run.

Top module: `gdo_steer`

## Requirements
- R1: During reset `ftw` equals NOMINAL_FTW, `ftw_upd` is 0 and `loop_closed` is 0.
- R2: In any clock edge at which `in_tracking` is 0, the next value of `ftw` is NOMINAL_FTW and `loop_closed` is 0. Estimates that arrive while not tracking cause no `ftw_upd`.
- R3: After tracking is seen, the next EST_SAMPLES valid estimates are collected. The slope is (last − first)/(EST_SAMPLES − 1), truncated toward zero. One cycle after the edge that takes the final estimate, `ftw` becomes NOMINAL_FTW − slope·COARSE_GAIN, saturated to [0, 2^32 − 1], with `ftw_upd` high. The earlier estimates of the window give no strobe.
- R4: The first valid estimate after the coarse correction becomes the setpoint and `loop_closed` goes to 1, with no strobe.
- R5: In closed loop, exactly every TICK_SAMPLES-th valid estimate is a control tick, and only ticks update `ftw`. The update is computed from that tick's own estimate.
- R6: On a tick, err = offset − setpoint and integ = integ + err. Then `ftw` = base − (err >>> `kp_shift`) − (integ >>> `ki_shift`), using arithmetic shifts, where base is the coarse-corrected word. The new word appears one cycle after the tick edge.
- R7: The tuning word saturates at 0 and at 2^32 − 1 and never wraps.
- R8: The integrator saturates at −2^(INT_W−1) and 2^(INT_W−1) − 1 and never wraps.
- R9: Loss of tracking clears the integrator. Reacquisition reruns the drift estimate, the coarse correction and the setpoint capture.
- R10: `ftw_upd` is a single-cycle pulse, high in each cycle where `ftw` has just taken a new value. One such pulse follows reset release.
- R11: With an oscillator whose frequency error is linear in the tuning word, the residual offset stays within 40 ns of the setpoint from the 50th control tick on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | One-cycle strobe: a new time-offset estimate |
| in_offset | input | OFS_W | Signed local-minus-satellite time offset, 1 ns per LSB |
| in_tracking | input | 1 | Solver reports satellite tracking |
| kp_shift | input | $clog2(INT_W) | Right-shift amount setting the proportional gain |
| ki_shift | input | $clog2(INT_W) | Right-shift amount setting the integral gain |
| ftw | output | FTW_W | Synthesizer frequency tuning word |
| ftw_upd | output | 1 | One-cycle strobe marking a new tuning word |
| loop_closed | output | 1 | Proportional-integral loop is active |

## Verification
A wrong sequencer state shows at the ports within one estimate. Examples are a coarse word appearing too early, a missing setpoint step in `loop_closed`, or a word leaving nominal while tracking is low. A corrupted integrator or a stale setpoint hides until the next control tick, then yields a tuning word that differs from the value computed from the estimates sent. A leftover integrator after tracking loss is exposed by the first tick after reacquisition with unit gains. Saturation faults show as words near the opposite rail, or as a changed word once the error returns to zero.

// File: rtl/gdo_pkg.sv
package gdo_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FREERUN,
        ST_ESTIMATE,
        ST_COARSE,
        ST_SETPT,
        ST_CLOSED
    } seq_state_e;

endpackage

// File: rtl/gdo_tick_div.sv
module gdo_tick_div #(
    parameter int unsigned TICK_SAMPLES = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic sample,
    output logic tick
);
    localparam int unsigned CW = $clog2(TICK_SAMPLES + 1);
    localparam logic [CW-1:0] LAST = CW'(TICK_SAMPLES - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        tick  = 1'b0;
        if (clear) begin
            cnt_d = '0;
        end else if (sample) begin
            if (cnt_q == LAST) begin
                cnt_d = '0;
                tick  = 1'b1;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/gdo_drift_est.sv
module gdo_drift_est #(
    parameter int unsigned N     = 250,
    parameter int unsigned OFS_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    sample,
    input  logic signed [OFS_W-1:0] offset,
    output logic                    done,
    output logic signed [OFS_W:0]   slope
);
    localparam int unsigned CW = $clog2(N + 1);
    localparam logic [CW-1:0] LAST = CW'(N - 1);
    localparam logic signed [OFS_W:0] SPAN = (OFS_W+1)'(N - 1);

    typedef struct packed {
        logic [CW-1:0]           cnt;
        logic signed [OFS_W-1:0] first;
        logic signed [OFS_W-1:0] last;
    } est_t;

    est_t q, d;
    logic signed [OFS_W:0] diff;

    always_comb begin
        d    = q;
        done = 1'b0;
        if (clear) begin
            d.cnt = '0;
        end else if (sample) begin
            if (q.cnt == '0) d.first = offset;
            d.last = offset;
            if (q.cnt == LAST) begin
                done  = 1'b1;
                d.cnt = '0;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_comb begin
        diff  = {q.last[OFS_W-1], q.last} - {q.first[OFS_W-1], q.first};
        slope = diff / SPAN;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/gdo_pi_core.sv
module gdo_pi_core #(
    parameter int unsigned OFS_W = 32,
    parameter int unsigned FTW_W = 32,
    parameter int unsigned INT_W = 40,
    parameter int unsigned SH_W  = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    load,
    input  logic signed [OFS_W-1:0] offset,
    input  logic signed [OFS_W-1:0] setpoint,
    input  logic [FTW_W-1:0]        base,
    input  logic [SH_W-1:0]         kp,
    input  logic [SH_W-1:0]         ki,
    output logic [FTW_W-1:0]        ftw_next
);
    localparam int unsigned W = INT_W + 3;
    localparam logic signed [INT_W-1:0] IMAX = {1'b0, {(INT_W-1){1'b1}}};
    localparam logic signed [INT_W-1:0] IMIN = {1'b1, {(INT_W-1){1'b0}}};
    localparam logic signed [W-1:0] FMAX = {{(W-FTW_W){1'b0}}, {FTW_W{1'b1}}};

    typedef struct packed {
        logic signed [OFS_W:0]   err;
        logic signed [INT_W-1:0] integ;
    } pi_t;

    pi_t q, d;
    logic signed [OFS_W:0]   err_new;
    logic signed [INT_W:0]   isum;
    logic signed [OFS_W:0]   p_term;
    logic signed [INT_W-1:0] i_term;
    logic signed [W-1:0]     p_ext, i_ext, base_ext, wide;

    always_comb begin
        d       = q;
        err_new = {offset[OFS_W-1], offset} - {setpoint[OFS_W-1], setpoint};
        isum    = {q.integ[INT_W-1], q.integ}
                + {{(INT_W-OFS_W){err_new[OFS_W]}}, err_new};
        if (clear) begin
            d.err   = '0;
            d.integ = '0;
        end else if (load) begin
            d.err = err_new;
            if (isum[INT_W] != isum[INT_W-1]) begin
                d.integ = isum[INT_W] ? IMIN : IMAX;
            end else begin
                d.integ = isum[INT_W-1:0];
            end
        end
    end

    always_comb begin
        p_term   = q.err >>> kp;
        i_term   = q.integ >>> ki;
        p_ext    = {{(W-OFS_W-1){p_term[OFS_W]}}, p_term};
        i_ext    = {{(W-INT_W){i_term[INT_W-1]}}, i_term};
        base_ext = {{(W-FTW_W){1'b0}}, base};
        wide     = base_ext - (p_ext + i_ext);
        if (wide < 0) begin
            ftw_next = '0;
        end else if (wide > FMAX) begin
            ftw_next = '1;
        end else begin
            ftw_next = wide[FTW_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/gdo_steer.sv
module gdo_steer
    import gdo_pkg::*;
#(
    parameter int unsigned       FTW_W        = 32,
    parameter int unsigned       OFS_W        = 32,
    parameter logic [FTW_W-1:0]  NOMINAL_FTW  = 32'h4000_0000,
    parameter int unsigned       EST_SAMPLES  = 250,
    parameter int unsigned       TICK_SAMPLES = 25,
    parameter int unsigned       INT_W        = 40,
    parameter int unsigned       GAIN_W       = 8,
    parameter logic [GAIN_W-1:0] COARSE_GAIN  = 8'd4,
    localparam int unsigned      SH_W         = $clog2(INT_W)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic signed [OFS_W-1:0] in_offset,
    input  logic                    in_tracking,
    input  logic [SH_W-1:0]         kp_shift,
    input  logic [SH_W-1:0]         ki_shift,
    output logic [FTW_W-1:0]        ftw,
    output logic                    ftw_upd,
    output logic                    loop_closed
);
    localparam int unsigned PW = OFS_W + GAIN_W + 3;
    localparam logic signed [PW-1:0] CMAX = {{(PW-FTW_W){1'b0}}, {FTW_W{1'b1}}};

    typedef struct packed {
        seq_state_e              state;
        logic [FTW_W-1:0]        ftw;
        logic                    upd;
        logic [FTW_W-1:0]        base;
        logic signed [OFS_W-1:0] setpt;
        logic                    pend;
    } ctl_t;

    ctl_t q, d;

    logic                  take;
    logic                  est_clear, est_done;
    logic signed [OFS_W:0] slope;
    logic                  tick_clear, tick;
    logic                  pi_clear, pi_load;
    logic [FTW_W-1:0]      pi_ftw;
    logic signed [PW-1:0]  slope_ext, gain_ext, prod, nom_ext, cwide;
    logic [FTW_W-1:0]      coarse_ftw;

    assign take       = in_valid && in_tracking;
    assign est_clear  = (q.state != ST_ESTIMATE);
    assign tick_clear = (q.state != ST_CLOSED);
    assign pi_clear   = (q.state != ST_CLOSED);
    assign pi_load    = tick && in_tracking;

    gdo_drift_est #(
        .N     (EST_SAMPLES),
        .OFS_W (OFS_W)
    ) u_est (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (est_clear),
        .sample (take),
        .offset (in_offset),
        .done   (est_done),
        .slope  (slope)
    );

    gdo_tick_div #(
        .TICK_SAMPLES (TICK_SAMPLES)
    ) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (tick_clear),
        .sample (take),
        .tick   (tick)
    );

    gdo_pi_core #(
        .OFS_W (OFS_W),
        .FTW_W (FTW_W),
        .INT_W (INT_W),
        .SH_W  (SH_W)
    ) u_pi (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (pi_clear),
        .load     (pi_load),
        .offset   (in_offset),
        .setpoint (q.setpt),
        .base     (q.base),
        .kp       (kp_shift),
        .ki       (ki_shift),
        .ftw_next (pi_ftw)
    );

    // coarse correction from the measured drift slope
    always_comb begin
        slope_ext = {{(PW-OFS_W-1){slope[OFS_W]}}, slope};
        gain_ext  = {{(PW-GAIN_W){1'b0}}, COARSE_GAIN};
        prod      = slope_ext * gain_ext;
        nom_ext   = {{(PW-FTW_W){1'b0}}, NOMINAL_FTW};
        cwide     = nom_ext - prod;
        if (cwide < 0) begin
            coarse_ftw = '0;
        end else if (cwide > CMAX) begin
            coarse_ftw = '1;
        end else begin
            coarse_ftw = cwide[FTW_W-1:0];
        end
    end

    // startup sequencer and tuning-word register
    always_comb begin
        d     = q;
        d.upd = 1'b0;
        unique case (q.state)
            ST_IDLE: begin
                d.state = ST_FREERUN;
                d.ftw   = NOMINAL_FTW;
                d.upd   = 1'b1;
            end
            ST_FREERUN: begin
                if (in_tracking) d.state = ST_ESTIMATE;
            end
            ST_ESTIMATE: begin
                if (est_done) d.state = ST_COARSE;
            end
            ST_COARSE: begin
                d.base  = coarse_ftw;
                d.ftw   = coarse_ftw;
                d.upd   = 1'b1;
                d.state = ST_SETPT;
            end
            ST_SETPT: begin
                if (take) begin
                    d.setpt = in_offset;
                    d.state = ST_CLOSED;
                end
            end
            ST_CLOSED: begin
                d.pend = pi_load;
                if (q.pend) begin
                    d.ftw = pi_ftw;
                    d.upd = 1'b1;
                end
            end
            default: begin
                d.state = ST_IDLE;
            end
        endcase

        if (!in_tracking && q.state != ST_IDLE && q.state != ST_FREERUN) begin
            d.state = ST_FREERUN;
            d.ftw   = NOMINAL_FTW;
            d.upd   = 1'b1;
            d.pend  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
            q.ftw   <= NOMINAL_FTW;
            q.base  <= NOMINAL_FTW;
        end else begin
            q <= d;
        end
    end

    assign ftw         = q.ftw;
    assign ftw_upd     = q.upd;
    assign loop_closed = (q.state == ST_CLOSED);

endmodule

// File: rtl/gdo_steer_chk.sv
module gdo_steer_chk #(
    parameter int unsigned      FTW_W       = 32,
    parameter logic [FTW_W-1:0] NOMINAL_FTW = 32'h4000_0000
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_tracking,
    input logic [FTW_W-1:0] ftw,
    input logic             ftw_upd,
    input logic             loop_closed
);

    // R2: no tracking at an edge forces nominal word and open loop after it
    assert_hold_nominal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_tracking |=> (ftw == NOMINAL_FTW && !loop_closed));

    // R2: closed loop only follows an edge that saw tracking
    assert_closed_needs_track_R2: assert property (@(posedge clk) disable iff (!rst_n)
        loop_closed |-> $past(in_tracking));

    // R4: the loop closes on an estimate
    assert_setpoint_on_sample_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(loop_closed) |-> $past(in_valid));

    // R10: any change of the word carries the strobe
    assert_strobe_marks_change_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ftw) |-> ftw_upd);

    // R10: strobe lasts one cycle
    assert_strobe_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ftw_upd |=> !ftw_upd);

endmodule

bind gdo_steer gdo_steer_chk #(
    .FTW_W       (FTW_W),
    .NOMINAL_FTW (NOMINAL_FTW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_tracking (in_tracking),
    .ftw         (ftw),
    .ftw_upd     (ftw_upd),
    .loop_closed (loop_closed)
);

// File: tb/gdo_steer_bench.sv
module gdo_steer_bench;

    localparam longint NOM    = 64'h0000_0000_4000_0000;
    localparam longint FMAXV  = 64'h0000_0000_FFFF_FFFF;
    localparam int     NEST   = 250;
    localparam int     NTICK  = 25;
    localparam longint GAIN   = 4;
    localparam int     IW     = 36;
    localparam longint IMAXV  = (64'sd1 <<< (IW - 1)) - 1;
    localparam longint IMINV  = -(64'sd1 <<< (IW - 1));
    localparam longint IDEAL  = NOM - 4002;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic signed [31:0] in_offset = '0;
    logic               in_tracking = 1'b0;
    logic [5:0]         kp_shift = 6'd3;
    logic [5:0]         ki_shift = 6'd6;
    logic [31:0]        ftw;
    logic               ftw_upd;
    logic               loop_closed;

    int     n_chk = 0;
    int     n_fail = 0;
    bit     finished = 1'b0;
    logic   got_upd, got_next, got_closed;
    longint got_ftw;
    longint acc = 0;
    longint base_exp = NOM;

    always #2 clk = ~clk;

    gdo_steer #(.INT_W(IW)) u_gdo_steer (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_offset   (in_offset),
        .in_tracking (in_tracking),
        .kp_shift    (kp_shift),
        .ki_shift    (ki_shift),
        .ftw         (ftw),
        .ftw_upd     (ftw_upd),
        .loop_closed (loop_closed)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic longint clampw(input longint x);
        if (x < 0) return 0;
        if (x > FMAXV) return FMAXV;
        return x;
    endfunction

    function automatic longint sati(input longint x);
        if (x > IMAXV) return IMAXV;
        if (x < IMINV) return IMINV;
        return x;
    endfunction

    // one estimate; result sampled one cycle after the taking edge
    task automatic send(input longint v);
        @(negedge clk);
        in_valid  = 1'b1;
        in_offset = 32'(v);
        @(negedge clk);
        in_valid  = 1'b0;
        @(negedge clk);
        got_upd    = ftw_upd;
        got_ftw    = longint'(ftw);
        got_closed = loop_closed;
        @(negedge clk);
        got_next = ftw_upd;
        @(negedge clk);
    endtask

    // oscillator model: quarter-ns accumulator, rate linear in the word
    task automatic msend(output longint v);
        longint rate;
        v    = acc >>> 2;
        rate = longint'(ftw) - IDEAL;
        send(v);
        acc  = acc + rate;
    endtask

    task automatic tick_with(input longint v);
        for (int s = 0; s < NTICK; s++) send(v);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        check(ftw == 32'(NOM), "R1", "ftw in reset", longint'(ftw), NOM);
        check(ftw_upd == 1'b0, "R1", "strobe in reset", longint'(ftw_upd), 0);
        check(loop_closed == 1'b0, "R1", "loop_closed in reset", longint'(loop_closed), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_freerun;
        longint v;
        int bad = 0;
        in_tracking = 1'b0;
        for (int i = 0; i < 10; i++) begin
            msend(v);
            if (got_upd || got_ftw != NOM) bad++;
        end
        check(bad == 0, "R2", "free-run word held nominal", bad, 0);
    endtask

    task automatic t_acquire;
        longint v, first, last, slope, setpt, err, integ, exp, res;
        int bad_cad = 0, bad_law = 0, early = 0;
        longint bad_act = 0, bad_exp = 0, max_res = 0;
        kp_shift = 6'd3;
        ki_shift = 6'd6;
        @(negedge clk);
        in_tracking = 1'b1;
        @(negedge clk);
        first = 0;
        last  = 0;
        for (int i = 0; i < NEST; i++) begin
            msend(v);
            if (i == 0) first = v;
            last = v;
            if (i < NEST - 1 && got_upd) early++;
        end
        check(early == 0, "R3", "no strobe inside window", early, 0);
        slope    = (last - first) / (NEST - 1);
        base_exp = clampw(NOM - slope * GAIN);
        check(got_upd == 1'b1, "R3", "coarse strobe", longint'(got_upd), 1);
        check(got_ftw == base_exp, "R3", "coarse word", got_ftw, base_exp);
        check(got_next == 1'b0, "R10", "strobe single cycle", longint'(got_next), 0);
        check(got_closed == 1'b0, "R4", "open before setpoint", longint'(got_closed), 0);

        msend(v);
        setpt = v;
        check(got_closed == 1'b1, "R4", "loop closes on setpoint", longint'(got_closed), 1);
        check(got_upd == 1'b0, "R4", "no strobe on setpoint", longint'(got_upd), 0);

        integ = 0;
        for (int t = 1; t <= 80; t++) begin
            for (int s = 1; s <= NTICK; s++) begin
                msend(v);
                res = (v > setpt) ? v - setpt : setpt - v;
                if (t >= 50 && res > max_res) max_res = res;
                if (s < NTICK) begin
                    if (got_upd) bad_cad++;
                end else begin
                    err   = v - setpt;
                    integ = sati(integ + err);
                    exp   = clampw(base_exp - (err >>> 3) - (integ >>> 6));
                    if (!got_upd) bad_cad++;
                    if (t == 1) begin
                        check(got_ftw == exp, "R6", "first tick word", got_ftw, exp);
                    end
                    if (got_ftw != exp && bad_law == 0) begin
                        bad_act = got_ftw;
                        bad_exp = exp;
                    end
                    if (got_ftw != exp) bad_law++;
                end
            end
        end
        check(bad_cad == 0, "R5", "tick cadence", bad_cad, 0);
        check(bad_law == 0, "R6", "law over all ticks", bad_act, bad_exp);
        check(max_res <= 40, "R11", "residual after tick 50", max_res, 40);
    endtask

    task automatic t_loss;
        @(negedge clk);
        in_tracking = 1'b0;
        @(negedge clk);
        check(ftw == 32'(NOM), "R2", "word nominal after loss", longint'(ftw), NOM);
        check(loop_closed == 1'b0, "R9", "loop opens on loss", longint'(loop_closed), 0);
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reacquire;
        longint exp;
        kp_shift = 6'd0;
        ki_shift = 6'd0;
        @(negedge clk);
        in_tracking = 1'b1;
        @(negedge clk);
        for (int i = 0; i < NEST; i++) send(0);
        check(got_upd == 1'b1 && got_ftw == NOM, "R9", "re-estimate zero slope", got_ftw, NOM);
        send(0);
        check(got_closed == 1'b1, "R9", "loop recloses", longint'(got_closed), 1);

        tick_with(1000);
        exp = NOM - 2000;
        check(got_ftw == exp, "R9", "integrator cleared", got_ftw, exp);

        ki_shift = 6'd35;
        tick_with(64'sh7FFF_FFFF);
        check(got_ftw == 0, "R7", "low clamp", got_ftw, 0);

        tick_with(-64'sh8000_0000);
        exp = 64'h0000_0000_C000_0000;
        check(got_ftw == exp, "R6", "large negative error", got_ftw, exp);

        ki_shift = 6'd0;
        tick_with(-64'sh8000_0000);
        check(got_ftw == FMAXV, "R7", "high clamp", got_ftw, FMAXV);

        for (int k = 0; k < 20; k++) tick_with(-64'sh8000_0000);
        ki_shift = 6'd31;
        tick_with(0);
        exp = NOM + 16;
        check(got_ftw == exp, "R8", "integrator held at floor", got_ftw, exp);
    endtask

    initial begin
        t_reset;
        t_freerun;
        t_acquire;
        t_loss;
        t_reacquire;
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule